// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block derives a repeating interrupt from a slow time base that arrives as a single-cycle enable strobe at 32.768 kHz. A four-bit rate code selects the period as a power of two of strobe cycles, and a separate enable bit gates the whole function. Each time the period elapses, two sticky status flags set and an interrupt request rises. All three stay high until a read strobe for the status register clears them.

The period boundaries are tied to a free-running 15-bit strobe count and not to the moment the rate was written. An interrupt always lands where the count becomes a multiple of the selected period. Rewriting the rate code or toggling the enable never restarts that count. The two smallest non-zero codes would give periods of one and two strobes. They are instead folded onto two slower rates.

Top module: `pit_periodic_irq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `per_flag`, `irq_flag` and `irq` are 0, and the strobe count starts from 0.
- R2: With `pie_en`=1 and rate code c in 3..15, a boundary occurs in a cycle with `tick`=1 in which the strobe count after that tick is a multiple of 2^(c-1). Both flags are 1 in the following cycle.
- R3: Rate code 1 produces the same boundaries as code 8 (period 128), and rate code 2 the same as code 9 (period 256).
- R4: Rate code 0 produces no boundaries, so the flags never set.
- R5: With `pie_en`=0 no boundary occurs for any rate code.
- R6: A cycle with `flag_rd`=1 and no boundary clears `per_flag`, `irq_flag` and `irq` in the following cycle. Without a read, set flags hold.
- R7: When a read and a boundary fall in the same cycle, the flags are 1 in the following cycle, so the event is not lost.
- R8: Changing the rate code or `pie_en` does not restart the strobe count. The next boundary is the next multiple of the new period on that unbroken count.
- R9: `irq` is 1 exactly when `per_flag` is 1, and `irq_flag` always equals `per_flag`.
- R10: The strobe count advances by one only in cycles with `tick`=1. Boundaries occur only in such cycles. The count wraps from 32767 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 32.768 kHz time-base strobe |
| rate_code | input | 4 | Period select; 0 disables, 1 and 2 alias to 8 and 9 |
| pie_en | input | 1 | Periodic interrupt enable |
| flag_rd | input | 1 | Status read strobe; clears the flags |
| per_flag | output | 1 | Sticky periodic event flag |
| irq_flag | output | 1 | Sticky interrupt-pending flag |
| irq | output | 1 | Interrupt request |

## Verification
Reaching the slowest rates and the 15-bit wrap from the ports is the hard part. Code 15 needs 16384 strobes per boundary, and the wrap needs 32768. The stimulus therefore drives the strobe on every clock for a long stretch. A behavioural model tracks the total strobe count and compares the flags on every clock. Rate changes in the middle of a period, and reads that fall on a boundary, are produced by switching codes at arbitrary points under irregular strobes and by reading on every cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef struct packed {
      logic irq;
      logic per;
   } pit_flags_t;

   // Shift amount for a rate code after aliasing of the two fastest codes.
   function automatic int unsigned pit_shift(input int unsigned code,
                                             input bit alias_en);
      if (alias_en && code == 1) return 7;
      if (alias_en && code == 2) return 8;
      if (code == 0) return 0;
      return code - 1;
   endfunction

endpackage

// File: rtl/pit_rate_dec.sv
module pit_rate_dec #(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned SHIFT_W  = 4,
   parameter bit          ALIAS_EN = 1'b1
) (
   input  logic [CODE_W-1:0]  code,
   output logic               active,
   output logic [SHIFT_W-1:0] shift
);
   localparam int unsigned NCODES = 2**CODE_W;

   if (SHIFT_W < $clog2(NCODES)) begin : g_bad_shift_w
      $error("pit_rate_dec: SHIFT_W too narrow for CODE_W");
   end

   assign active = (code != '0);

   if (ALIAS_EN) begin : g_alias
      always_comb begin
         unique case (code)
            CODE_W'(1): shift = SHIFT_W'(pit_pkg::pit_shift(1, 1'b1));
            CODE_W'(2): shift = SHIFT_W'(pit_pkg::pit_shift(2, 1'b1));
            default:    shift = (code == '0) ? '0 : SHIFT_W'(code - CODE_W'(1));
         endcase
      end
   end else begin : g_plain
      assign shift = (code == '0) ? '0 : SHIFT_W'(code - CODE_W'(1));
   end
endmodule

// File: rtl/pit_tick_count.sv
module pit_tick_count #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("pit_tick_count: CNT_W must be at least 2");
   end

   assign cnt_nxt = cnt + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= cnt_nxt;
   end

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
   p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == CNT_W'($past(cnt) + ONE)));
endmodule

// File: rtl/pit_edge_det.sv
module pit_edge_det #(
   parameter int unsigned CNT_W   = 15,
   parameter int unsigned SHIFT_W = 4
) (
   input  logic [CNT_W-1:0]   cnt_nxt,
   input  logic [SHIFT_W-1:0] shift,
   input  logic               active,
   input  logic               pie_en,
   input  logic               tick,
   output logic               hit
);
   logic [CNT_W-1:0] low_mask;

   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign low_mask[i] = (i < int'(shift));
   end

   assign hit = tick && pie_en && active && ((cnt_nxt & low_mask) == '0);
endmodule

// File: rtl/pit_flag_reg.sv
module pit_flag_reg (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              clr,
   output pit_pkg::pit_flags_t flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else if (hit) begin
         flags.per <= 1'b1;
         flags.irq <= 1'b1;
      end else if (clr) begin
         flags <= '0;
      end
   end

   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (flags.per && flags.irq));
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> (!flags.per && !flags.irq));
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !hit) |=> $stable(flags));
endmodule

// File: rtl/pit_periodic_irq.sv
module pit_periodic_irq #(
   parameter int unsigned CNT_W    = 15,
   parameter int unsigned CODE_W   = 4,
   parameter bit          ALIAS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CODE_W-1:0] rate_code,
   input  logic              pie_en,
   input  logic              flag_rd,
   output logic              per_flag,
   output logic              irq_flag,
   output logic              irq
);
   localparam int unsigned SHIFT_W   = $clog2(2**CODE_W);
   localparam int unsigned MAX_SHIFT = 2**CODE_W - 2;

   if (CNT_W < MAX_SHIFT) begin : g_bad_width
      $error("pit_periodic_irq: CNT_W cannot hold the longest period");
   end

   logic [CNT_W-1:0]   cnt, cnt_nxt;
   logic [SHIFT_W-1:0] shift;
   logic               active, hit;
   pit_pkg::pit_flags_t flags;

   pit_rate_dec #(.CODE_W(CODE_W), .SHIFT_W(SHIFT_W), .ALIAS_EN(ALIAS_EN)) i_dec (
      .code(rate_code), .active(active), .shift(shift));

   pit_tick_count #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_nxt(cnt_nxt));

   pit_edge_det #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) i_det (
      .cnt_nxt(cnt_nxt), .shift(shift), .active(active), .pie_en(pie_en),
      .tick(tick), .hit(hit));

   pit_flag_reg i_flags (
      .clk(clk), .rst_n(rst_n), .hit(hit), .clr(flag_rd), .flags(flags));

   assign per_flag = flags.per;
   assign irq_flag = flags.irq;
   assign irq      = flags.irq;

   p_no_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_code == '0) |-> !hit);
   p_no_pie_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pie_en |-> !hit);
   p_tick_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |-> !hit);
   p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq == per_flag);
   p_new_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(per_flag) |-> $past(tick));
endmodule

// File: tb/test_pit_periodic_irq.sv
module test_pit_periodic_irq;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [3:0] rate_code = 4'd0;
   logic       pie_en = 1'b0;
   logic       flag_rd = 1'b0;
   logic       per_flag, irq_flag, irq;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   string tag = "R1";

   // reference model state
   int  m_count = 0;
   bit  m_flag = 1'b0;
   int  m_sets = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pit_periodic_irq i_pit_periodic_irq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rate_code(rate_code),
      .pie_en(pie_en), .flag_rd(flag_rd), .per_flag(per_flag),
      .irq_flag(irq_flag), .irq(irq));

   function automatic int period_of(input int code);
      int c;
      c = code;
      if (c == 1) c = 8;
      if (c == 2) c = 9;
      return 1 << (c - 1);
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_count = 0;
         m_flag  = 1'b0;
      end else begin
         bit b;
         b = 1'b0;
         if (tick) begin
            m_count = (m_count + 1) % 32768;
            if (pie_en && rate_code != 0 && (m_count % period_of(rate_code)) == 0)
               b = 1'b1;
         end
         if (b) begin
            m_flag = 1'b1;
            m_sets++;
         end else if (flag_rd) begin
            m_flag = 1'b0;
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         check("R1", "per_flag in reset", per_flag, 0);
         check("R1", "irq in reset", irq, 0);
      end else begin
         check(tag, "per_flag", per_flag, m_flag);
         check(tag, "irq_flag", irq_flag, m_flag);
         check("R9", "irq vs per_flag", irq, per_flag);
      end
      if (cycles > WATCHDOG) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // tick_mode: 0 none, 1 every cycle, 2 random one in three
   // rd_mode: 0 none, 1 every cycle, 2 random one in five
   task automatic run(input int n, input int tick_mode, input int rd_mode);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         tick    = (tick_mode == 1) || (tick_mode == 2 && $urandom_range(0, 2) == 0);
         flag_rd = (rd_mode == 1) || (rd_mode == 2 && $urandom_range(0, 4) == 0);
      end
   endtask

   int sets_before;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "per_flag after reset", per_flag, 0);

      // R2: fastest legal code with continuous ticks, then sparse ticks
      tag = "R2"; rate_code = 4'd3; pie_en = 1'b1;
      run(60, 1, 2);
      rate_code = 4'd5;
      run(400, 2, 2);

      // R3: aliased codes
      tag = "R3"; rate_code = 4'd1;
      run(700, 1, 2);
      rate_code = 4'd2;
      run(1200, 1, 2);
      rate_code = 4'd8;
      run(600, 1, 2);

      // R4: code zero; flags cleared first then observed
      tag = "R4"; rate_code = 4'd0;
      run(2, 0, 1);
      sets_before = m_sets;
      run(600, 1, 0);
      check("R4", "events with code 0", m_sets - sets_before, 0);

      // R5: enable low
      tag = "R5"; rate_code = 4'd3; pie_en = 1'b0;
      run(300, 1, 0);
      check("R5", "per_flag with pie off", per_flag, 0);

      // R6: read clears held flag
      tag = "R6"; pie_en = 1'b1;
      run(20, 1, 0);
      run(1, 0, 1);
      run(1, 0, 0);
      check("R6", "per_flag after read", per_flag, 0);

      // R7: read on every cycle meets boundaries
      tag = "R7";
      run(80, 1, 1);

      // R8: rate and enable changes mid-period
      tag = "R8";
      for (int j = 0; j < 12; j++) begin
         rate_code = 4'($urandom_range(3, 9));
         pie_en = ($urandom_range(0, 3) != 0);
         run($urandom_range(20, 300), 2, 2);
      end

      // R10: no ticks, state must hold
      tag = "R10"; pie_en = 1'b1; rate_code = 4'd3;
      run(1, 0, 1);
      run(150, 0, 0);
      check("R10", "per_flag without ticks", per_flag, 0);

      // R2/R10: slowest rate across the count wrap
      tag = "R2"; rate_code = 4'd15;
      run(2, 0, 1);
      sets_before = m_sets;
      run(33000, 1, 0);
      check("R10", "events over one wrap at code 15", m_sets - sets_before, 2);
      run(1, 0, 1);
      run(1, 0, 0);
      check("R6", "per_flag after final read", per_flag, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule